// File: doc/BRIEF.md
# Instruction Context Propagation Engine

This block lets a single setup command attach one context word to a run of upcoming instructions, so the context does not have to travel with each instruction. It keeps seven context slots, selected by an index of 1 to 7. Each slot holds a 32-bit context word and a 40-bit schedule shift register. Bit 0 of the schedule says whether that slot's context applies to the next instruction issued.

A setup command writes the slot's context word. It also appends a run of schedule bits behind the bits the slot already has pending. On every issued instruction, the engine ORs together the contexts of all slots whose schedule bit 0 is set. It presents this merged word one cycle later, with a valid flag. It raises an illegal-instruction flag when the selected contexts carry different type codes. Every slot then shifts down by one. Decoding the instruction stream and interpreting the merged bits belong to the blocks around this one.

Top module: `ctx_prop_engine`

## Requirements
- R1: A synchronous active-low reset empties every schedule, clears every context and fill offset, and drives `merged_ctx`, `merged_valid`, `illegal` and `overflow` to zero. A step issued straight after reset yields `merged_valid` = 0.
- R2: A setup is accepted only when `setup_kind` is 3'b000 and `setup_index` is 1 to 7; it then writes `setup_ctx` as the context of slot `setup_index`. Let p be the lowest set bit of `setup_imm`. The setup appends 20 − p schedule bits, taken from `setup_imm[p+1]` up to `setup_imm[20]`, and `setup_imm[p+1]` governs the earliest instruction. An immediate of zero appends nothing.
- R3: Appended bits go in at the slot's current fill offset, behind every bit still pending, and the offset then advances by the count.
- R4: When `step_valid` is high, the next cycle shows `merged_ctx` as the OR of the contexts of all slots whose schedule bit 0 is 1, and `merged_valid` high if and only if at least one slot is selected. After a cycle without a step, both are zero.
- R5: Each step shifts every schedule right by one. A slot's fill offset drops by one and holds at 0 once the slot is empty, so an empty slot is never selected.
- R6: The type code of a context is bits [31:27] (00000 = RM, 00001 = swizzle, 00010 = remap). `illegal` is high in the cycle after a step whose selected slots do not all share one type code, and only together with `merged_valid`.
- R7: A setup with `setup_kind` other than 3'b000, or with `setup_index` = 0, changes no context, no schedule and no offset.
- R8: Schedule bits that would land at position 40 or beyond are discarded, the fill offset stops at 40, and `overflow` is high for one cycle after that setup.
- R9: When a setup and a step occur in the same cycle, the shift happens first and the new bits go in at the decremented offset. The merge for that step uses the slot's context from before the write.
- R10: A later setup on an index replaces that slot's context for all of its still-pending schedule bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_valid | input | 1 | An instruction issues this cycle |
| setup_valid | input | 1 | A setup command is present |
| setup_kind | input | 3 | Setup kind field; 3'b000 is accepted |
| setup_index | input | 3 | Target slot, 1 to 7 |
| setup_ctx | input | 32 | Context word for the target slot |
| setup_imm | input | 21 | Marker-terminated schedule immediate |
| merged_ctx | output | 32 | OR of selected contexts for the last step |
| merged_valid | output | 1 | At least one slot was selected at the last step |
| illegal | output | 1 | Selected contexts had mixed type codes |
| overflow | output | 1 | Last setup lost schedule bits past position 40 |

## Verification
The hardest state to reach is a full slot. Filling one takes two 20-bit appends before a third spills past position 40, with no step in between. Then the slot must drain completely so the offset reaches 0 before a new append shows where it lands. A directed sequence does exactly this, and also issues a setup and a step in the same cycle on a slot that still has bits pending. A long random phase then mixes type codes across slots to provoke conflicts, and compares every output each cycle against a queue-based model.

// File: rtl/ctxp_pkg.sv
// Package: shared sizes for the context propagation engine.
// Assumes: the setup immediate is narrower than the schedule register.
package ctxp_pkg;
    parameter int unsigned CTX_W   = 32;
    parameter int unsigned SLOT_N  = 7;
    parameter int unsigned SCHED_W = 40;
    parameter int unsigned IMM_W   = 21;
    parameter int unsigned TYPE_W  = 5;
    parameter int unsigned KIND_W  = 3;
    parameter int unsigned IDX_W   = 3;
    localparam int unsigned OFF_W  = $clog2(SCHED_W + 1);
    localparam int unsigned CNT_W  = $clog2(IMM_W);
    localparam logic [KIND_W-1:0] KIND_RM = '0;
endpackage

// File: rtl/ctxp_imm_decode.sv
// Module: ctxp_imm_decode
// Turns a marker-terminated immediate into right-aligned schedule bits
// and a bit count. The lowest set bit is the marker; the bits above it
// are the schedule, and the one just above the marker applies first.
// Assumes: a zero immediate means "append nothing".
module ctxp_imm_decode #(
    parameter int unsigned IMM_W = 21,
    parameter int unsigned CNT_W = 5
) (
    input  logic [IMM_W-1:0] imm_i,
    output logic [IMM_W-1:0] bits_o,
    output logic [CNT_W-1:0] cnt_o
);
    // Locate the marker and align the schedule bits to bit 0.
    always_comb begin
        int unsigned mark;
        logic        found;
        mark  = 0;
        found = 1'b0;
        for (int i = IMM_W - 1; i >= 0; i--) begin
            if (imm_i[i]) begin
                mark  = i;
                found = 1'b1;
            end
        end
        if (found) begin
            cnt_o  = CNT_W'(IMM_W - 1 - mark);
            bits_o = imm_i >> (mark + 1);
        end else begin
            cnt_o  = '0;
            bits_o = '0;
        end
    end
endmodule

// File: rtl/ctxp_slot.sv
// Module: ctxp_slot
// One context slot: a context word, a schedule shift register and its
// fill offset. A step shifts first; a write then appends at the
// shifted offset, truncating at the register top.
// Assumes: wr_bits_i is zero above wr_cnt_i.
module ctxp_slot #(
    parameter int unsigned CTX_W   = 32,
    parameter int unsigned SCHED_W = 40,
    parameter int unsigned IMM_W   = 21,
    parameter int unsigned OFF_W   = 6,
    parameter int unsigned CNT_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_i,
    input  logic               wr_i,
    input  logic [CTX_W-1:0]   wr_ctx_i,
    input  logic [IMM_W-1:0]   wr_bits_i,
    input  logic [CNT_W-1:0]   wr_cnt_i,
    output logic [CTX_W-1:0]   ctx_o,
    output logic               sel_o,
    output logic               ovf_o
);
    localparam int unsigned SUM_W  = OFF_W + 1;
    localparam int unsigned WIDE_W = SCHED_W + IMM_W;
    localparam logic [SUM_W-1:0] LIMIT = SUM_W'(SCHED_W);

    logic [CTX_W-1:0]   ctx_q, ctx_d;
    logic [SCHED_W-1:0] sched_q, sched_d, sched_sh;
    logic [OFF_W-1:0]   off_q, off_d, off_sh;
    logic [WIDE_W-1:0]  placed;
    logic [SUM_W-1:0]   sum;

    // Shift-then-append next-state computation.
    always_comb begin
        off_sh   = (step_i && off_q != '0) ? off_q - 1'b1 : off_q;
        sched_sh = step_i ? (sched_q >> 1) : sched_q;
        placed   = {{SCHED_W{1'b0}}, wr_bits_i} << off_sh;
        sum      = {1'b0, off_sh} + SUM_W'(wr_cnt_i);
        ovf_o    = wr_i && (sum > LIMIT);
        ctx_d    = ctx_q;
        sched_d  = sched_sh;
        off_d    = off_sh;
        if (wr_i) begin
            ctx_d   = wr_ctx_i;
            sched_d = sched_sh | placed[SCHED_W-1:0];
            off_d   = ovf_o ? OFF_W'(SCHED_W) : sum[OFF_W-1:0];
        end
    end

    // Slot state registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q   <= '0;
            sched_q <= '0;
            off_q   <= '0;
        end else begin
            ctx_q   <= ctx_d;
            sched_q <= sched_d;
            off_q   <= off_d;
        end
    end

    assign ctx_o = ctx_q;
    assign sel_o = sched_q[0];

    // R8
    off_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        off_q <= OFF_W'(SCHED_W));
    // R3
    clean_above_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sched_q >> off_q) == '0);
    // R5
    step_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && !wr_i && off_q != '0 |=> off_q == $past(off_q) - 1'b1);
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i && !wr_i |=> $stable(sched_q) && $stable(ctx_q));
endmodule

// File: rtl/ctxp_merge.sv
// Module: ctxp_merge
// ORs the contexts of all selected slots and flags a type conflict when
// the selected type codes (top TYPE_W bits) are not all equal.
// Assumes: purely combinational; the caller registers the result.
module ctxp_merge #(
    parameter int unsigned SLOT_N = 7,
    parameter int unsigned CTX_W  = 32,
    parameter int unsigned TYPE_W = 5
) (
    input  logic [SLOT_N-1:0]            sel_i,
    input  logic [SLOT_N-1:0][CTX_W-1:0] ctx_i,
    output logic [CTX_W-1:0]             merged_o,
    output logic                         any_o,
    output logic                         conflict_o
);
    logic [TYPE_W-1:0] or_t, and_t;

    // OR-reduce selected contexts; differing type bits show as or != and.
    always_comb begin
        merged_o = '0;
        or_t     = '0;
        and_t    = '1;
        any_o    = 1'b0;
        for (int i = 0; i < SLOT_N; i++) begin
            if (sel_i[i]) begin
                merged_o = merged_o | ctx_i[i];
                or_t     = or_t  | ctx_i[i][CTX_W-1 -: TYPE_W];
                and_t    = and_t & ctx_i[i][CTX_W-1 -: TYPE_W];
                any_o    = 1'b1;
            end
        end
        conflict_o = any_o && (or_t != and_t);
    end
endmodule

// File: rtl/ctx_prop_engine.sv
// Module: ctx_prop_engine
// Top of the context propagation engine: decodes setup commands, keeps
// SLOT_N scheduled context slots, and registers the merged context,
// valid, illegal and overflow flags one cycle after each event.
// Assumes: at most one setup and one step per cycle.
module ctx_prop_engine
    import ctxp_pkg::*;
#(
    parameter int unsigned P_CTX_W   = CTX_W,
    parameter int unsigned P_SLOT_N  = SLOT_N,
    parameter int unsigned P_SCHED_W = SCHED_W,
    parameter int unsigned P_IMM_W   = IMM_W,
    parameter int unsigned P_TYPE_W  = TYPE_W,
    parameter int unsigned P_KIND_W  = KIND_W,
    parameter int unsigned P_IDX_W   = IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_valid,
    input  logic                 setup_valid,
    input  logic [P_KIND_W-1:0]  setup_kind,
    input  logic [P_IDX_W-1:0]   setup_index,
    input  logic [P_CTX_W-1:0]   setup_ctx,
    input  logic [P_IMM_W-1:0]   setup_imm,
    output logic [P_CTX_W-1:0]   merged_ctx,
    output logic                 merged_valid,
    output logic                 illegal,
    output logic                 overflow
);
    localparam int unsigned L_OFF_W = $clog2(P_SCHED_W + 1);
    localparam int unsigned L_CNT_W = $clog2(P_IMM_W);

    logic                              accept;
    logic [P_IMM_W-1:0]                dec_bits;
    logic [L_CNT_W-1:0]                dec_cnt;
    logic [P_SLOT_N-1:0]               slot_wr, slot_sel, slot_ovf;
    logic [P_SLOT_N-1:0][P_CTX_W-1:0]  slot_ctx;
    logic [P_CTX_W-1:0]                mrg_ctx;
    logic                              mrg_any, mrg_conflict;

    // Accept only RM-kind setups aimed at a real slot.
    assign accept = setup_valid && (setup_kind == P_KIND_W'(KIND_RM))
                    && (setup_index != '0);

    ctxp_imm_decode #(.IMM_W(P_IMM_W), .CNT_W(L_CNT_W)) i_dec (
        .imm_i  (setup_imm),
        .bits_o (dec_bits),
        .cnt_o  (dec_cnt)
    );

    for (genvar g = 0; g < P_SLOT_N; g++) begin : g_slot
        assign slot_wr[g] = accept && (setup_index == P_IDX_W'(g + 1));
        ctxp_slot #(
            .CTX_W(P_CTX_W), .SCHED_W(P_SCHED_W), .IMM_W(P_IMM_W),
            .OFF_W(L_OFF_W), .CNT_W(L_CNT_W)
        ) i_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .step_i    (step_valid),
            .wr_i      (slot_wr[g]),
            .wr_ctx_i  (setup_ctx),
            .wr_bits_i (dec_bits),
            .wr_cnt_i  (dec_cnt),
            .ctx_o     (slot_ctx[g]),
            .sel_o     (slot_sel[g]),
            .ovf_o     (slot_ovf[g])
        );
    end

    ctxp_merge #(.SLOT_N(P_SLOT_N), .CTX_W(P_CTX_W), .TYPE_W(P_TYPE_W)) i_merge (
        .sel_i      (slot_sel),
        .ctx_i      (slot_ctx),
        .merged_o   (mrg_ctx),
        .any_o      (mrg_any),
        .conflict_o (mrg_conflict)
    );

    // Output registers: results appear the cycle after a step or setup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            merged_ctx   <= '0;
            merged_valid <= 1'b0;
            illegal      <= 1'b0;
            overflow     <= 1'b0;
        end else begin
            merged_ctx   <= step_valid ? mrg_ctx : '0;
            merged_valid <= step_valid && mrg_any;
            illegal      <= step_valid && mrg_conflict;
            overflow     <= |slot_ovf;
        end
    end

    // R6
    conflict_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrg_conflict |-> $countones(slot_sel) >= 2);
    // R6
    illegal_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> merged_valid);
    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_valid |=> !merged_valid && merged_ctx == '0 && !illegal);
    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !overflow);
    // R2
    one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_wr));
endmodule

// File: tb/test_ctx_prop_engine.sv
`timescale 1ns/1ps
module test_ctx_prop_engine;
    localparam int SLOTS = 7;
    localparam int DEPTH = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_valid = 1'b0, setup_valid = 1'b0;
    logic [2:0]  setup_kind = '0, setup_index = '0;
    logic [31:0] setup_ctx = '0;
    logic [20:0] setup_imm = '0;
    logic [31:0] merged_ctx;
    logic        merged_valid, illegal, overflow;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    bit          mq [SLOTS][$];
    logic [31:0] mctx [SLOTS];

    always #4 clk = ~clk;

    ctx_prop_engine i_ctx_prop_engine (
        .clk(clk), .rst_n(rst_n), .step_valid(step_valid),
        .setup_valid(setup_valid), .setup_kind(setup_kind),
        .setup_index(setup_index), .setup_ctx(setup_ctx),
        .setup_imm(setup_imm), .merged_ctx(merged_ctx),
        .merged_valid(merged_valid), .illegal(illegal), .overflow(overflow)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Schedule immediate with n bits of pattern above a marker.
    function automatic logic [20:0] mk_imm(input logic [19:0] pat, input int n);
        logic [20:0] v;
        v = 21'(1) << (20 - n);
        if (n > 0) v = v | (21'(pat) << (21 - n));
        return v;
    endfunction

    // One clock: drive inputs, advance the model, compare after the edge.
    task automatic run_cycle(input bit st, input bit sv, input logic [2:0] kind,
                             input logic [2:0] idx, input logic [31:0] c,
                             input logic [20:0] imm, input string tag);
        logic [31:0] e_ctx;
        logic [4:0]  ft;
        bit e_val, e_ill, e_ovf, b;
        int p;
        step_valid = st; setup_valid = sv; setup_kind = kind;
        setup_index = idx; setup_ctx = c; setup_imm = imm;
        e_ctx = '0; e_val = 0; e_ill = 0; e_ovf = 0; ft = '0;
        if (st) begin
            for (int s = 0; s < SLOTS; s++) begin
                b = (mq[s].size() > 0) ? mq[s].pop_front() : 1'b0;
                if (b) begin
                    if (e_val && mctx[s][31:27] != ft) e_ill = 1;
                    if (!e_val) ft = mctx[s][31:27];
                    e_ctx = e_ctx | mctx[s];
                    e_val = 1;
                end
            end
        end
        if (sv && kind == 3'b000 && idx != 3'd0) begin
            mctx[idx - 1] = c;
            p = -1;
            for (int k = 20; k >= 0; k--) if (imm[k]) p = k;
            if (p >= 0) begin
                for (int k = p + 1; k <= 20; k++) begin
                    if (mq[idx - 1].size() < DEPTH) mq[idx - 1].push_back(imm[k]);
                    else e_ovf = 1;
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk(tag, "merged_ctx", merged_ctx, e_ctx);
        chk(tag, "merged_valid", 32'(merged_valid), 32'(e_val));
        chk(tag, "illegal", 32'(illegal), 32'(e_ill));
        chk(tag, "overflow", 32'(overflow), 32'(e_ovf));
    endtask

    task automatic steps(input int n, input string tag);
        for (int i = 0; i < n; i++) run_cycle(1, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic setup(input logic [2:0] idx, input logic [31:0] c,
                         input logic [20:0] imm, input string tag);
        run_cycle(0, 1, 3'b000, idx, c, imm, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < SLOTS; s++) mctx[s] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs are clear while in reset
        chk("R1", "merged_ctx", merged_ctx, 0);
        chk("R1", "merged_valid", 32'(merged_valid), 0);
        chk("R1", "overflow", 32'(overflow), 0);
        rst_n = 1'b1;
        steps(2, "R1");

        // R2, R3: two appends on slot 1, read out in order
        setup(3'd1, 32'h0000_00A5, mk_imm(20'b1011, 4), "R2");
        setup(3'd1, 32'h0000_00A5, mk_imm(20'b01, 2), "R3");
        steps(8, "R3");
        // R2: zero immediate appends nothing; marker at bit 20 appends nothing
        setup(3'd2, 32'h0000_0F00, 21'd0, "R2");
        setup(3'd2, 32'h0000_0F00, 21'h10_0000, "R2");
        steps(3, "R2");

        // R4: two RM contexts overlap and OR together
        setup(3'd4, 32'h0000_1100, mk_imm(20'b111, 3), "R4");
        setup(3'd6, 32'h0000_0022, mk_imm(20'b101, 3), "R4");
        steps(4, "R4");

        // R6: RM and swizzle selected together
        setup(3'd3, 32'h0800_0003, mk_imm(20'b11, 2), "R6");
        setup(3'd5, 32'h0000_0300, mk_imm(20'b01, 2), "R6");
        setup(3'd7, 32'h1000_0040, mk_imm(20'b10, 2), "R6");
        steps(3, "R6");

        // R7: wrong kind and index 0 are ignored
        run_cycle(0, 1, 3'b001, 3'd2, 32'h0000_FFFF, mk_imm(20'b1, 1), "R7");
        run_cycle(0, 1, 3'b010, 3'd2, 32'h0000_FFFF, mk_imm(20'b1, 1), "R7");
        run_cycle(0, 1, 3'b000, 3'd0, 32'h0000_FFFF, mk_imm(20'b1, 1), "R7");
        steps(3, "R7");

        // R8: fill slot 5 past 40 bits, then drain fully
        setup(3'd5, 32'h0000_0005, mk_imm(20'hFFFFF, 20), "R8");
        setup(3'd5, 32'h0000_0005, mk_imm(20'h0000F, 20), "R8");
        setup(3'd5, 32'h0000_0005, mk_imm(20'h00003, 3), "R8");
        steps(42, "R5");
        // R5: offset held at 0, new bits apply from the very next step
        setup(3'd5, 32'h0000_0055, mk_imm(20'b1, 1), "R5");
        steps(2, "R5");

        // R9: setup and step together on a slot with pending bits
        setup(3'd2, 32'h0000_0010, mk_imm(20'b11, 2), "R9");
        run_cycle(1, 1, 3'b000, 3'd2, 32'h0000_0020, mk_imm(20'b101, 3), "R9");
        steps(5, "R9");

        // R10: rewrite of context affects the pending bits
        setup(3'd6, 32'h0000_0100, mk_imm(20'b1111, 4), "R10");
        steps(1, "R10");
        setup(3'd6, 32'h0000_0200, 21'd0, "R10");
        steps(4, "R10");

        // R4: random mix of setups, steps and type codes
        for (int i = 0; i < 600; i++) begin
            logic [31:0] c;
            logic [2:0]  kd;
            c = $urandom;
            c[31:27] = 5'($urandom_range(0, 2));
            kd = ($urandom_range(0, 5) == 0) ? 3'($urandom) : 3'b000;
            run_cycle(1'($urandom), 1'($urandom), kd, 3'($urandom), c,
                      21'($urandom), "R4");
        end
        steps(45, "R5");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule